// File: doc/BRIEF.md
# Host Data Port Width Adapter

This block connects a host data port to two internal byte streams. The host port can run 8 or 16 bits wide. One stream carries coded data and the other carries context-table entries; a select input picks which one a host access uses. A host write to the data address is split into bytes and sent out through a valid/ready handshake. A host read to the data address collects bytes from the incoming stream and returns them. In 16-bit mode the first byte sits on the low lane and the second on the high lane. While a host access is in progress the host holds its request. The block acknowledges with a single-cycle pulse once the stream side has completed the access, so an empty or full stream stalls the host.

When the coded stream ends, the byte flagged as last closes it. If the stream ended after an odd number of bytes, the adapter adds one zero byte so that the output stays word aligned. Context-table entries always use only the low byte. Bit 7 of an entry is the expected symbol and bits 6:0 are a state number. The block also holds the processed-line counter. The host reads it back as a word, or as two bytes with the high half captured when the low half is read. The counter raises a done flag when it reaches a programmed target.

Host addresses: 0 = data low byte, 1 = data high byte, 2 = line count low byte, 3 = line count high byte.

Top module: `hdp_width_adapter`

## Requirements
- R1: With `bus16`=0 and `ctx_sel`=0, a write to address 0 sends `host_wdata[7:0]` as one byte on the out stream. `host_ack` pulses after that byte is accepted.
- R2: With `bus16`=1 and `ctx_sel`=0, a word write to address 0 sends two bytes: `host_wdata[7:0]` first, then `host_wdata[15:8]`.
- R3: A coded read at address 0 returns `{8'h00, byte}` in 8-bit mode. In 16-bit mode it returns `{second byte, first byte}`.
- R4: These accesses are errors: an odd address in 16-bit mode, address 1 in 8-bit mode, and any write to address 2 or 3. Each is acknowledged with `host_err`=1, and no stream byte is sent or consumed.
- R5: Bytes consumed from the coded in stream are counted since the last end or `proc_start`. If that count is odd when a byte with `in_last`=1 is consumed, the next delivered byte is 0x00, and it consumes nothing from the stream.
- R6: With `ctx_sel`=1, a write sends only `host_wdata[7:0]`, as one byte, in either mode. If `host_wdata[6:0]` is above STATE_MAX (112), the write is rejected with `host_err`=1 and nothing is sent. Bit 7 is not constrained.
- R7: With `ctx_sel`=1, a read consumes one byte and returns `{8'h00, byte}` in either mode. Context bytes never count toward padding.
- R8: The line count starts at 0, increases by one on each `line_tick`, and returns to 0 on `proc_start`. In 16-bit mode, a word read at address 2 returns the full count.
- R9: In 8-bit mode, a read at address 2 returns the count's low byte and captures its high byte. A read at address 3 returns the captured byte, even if the count has changed since.
- R10: `line_done` rises when a tick brings the count equal to `line_target`. While it is set, ticks are ignored. `proc_start` clears it.
- R11: `out_valid` with its data stays stable until `out_ready`. `in_ready` is high only while a read waits for a stream byte. `host_ack` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus16 | input | 1 | 1 = 16-bit host mode, 0 = 8-bit |
| ctx_sel | input | 1 | 1 = context-table transfers, 0 = coded data |
| host_wr | input | 1 | Write request, held until ack |
| host_rd | input | 1 | Read request, held until ack |
| host_addr | input | 2 | Host byte address |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, valid with ack |
| host_ack | output | 1 | One-cycle completion pulse |
| host_err | output | 1 | Access rejected, valid with ack |
| out_valid | output | 1 | Out stream byte valid |
| out_data | output | 8 | Out stream byte |
| out_ready | input | 1 | Out stream sink ready |
| in_valid | input | 1 | In stream byte valid |
| in_data | input | 8 | In stream byte |
| in_last | input | 1 | Byte closes the coded stream |
| in_ready | output | 1 | Adapter takes the in stream byte |
| proc_start | input | 1 | Process-start command |
| line_tick | input | 1 | One line processed |
| line_target | input | 16 | Programmed line count |
| line_done | output | 1 | Target reached |

## Verification
The bench builds the block with its default STATE_MAX of 112. This puts the accepted entry 112 and the rejected entry 113 next to each other, with bit 7 set and clear. Random stream lengths in both bus modes exercise odd and even endings, with the pad landing in both the high lane and the next byte read. Random ready and valid stalls stretch every transfer. Line-count values near 0x1FF/0x201 make a captured high byte differ from the live one.

// File: rtl/hdp_width_adapter.sv
module hdp_width_adapter #(
  parameter int STATE_MAX = 112
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus16,
  input  logic        ctx_sel,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [1:0]  host_addr,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  output logic        host_ack,
  output logic        host_err,
  output logic        out_valid,
  output logic [7:0]  out_data,
  input  logic        out_ready,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  output logic        in_ready,
  input  logic        proc_start,
  input  logic        line_tick,
  input  logic [15:0] line_target,
  output logic        line_done
);
  localparam logic [6:0] SMAX = 7'(STATE_MAX);

  typedef enum logic [1:0] {S_IDLE, S_WR, S_RD, S_ACK} st_t;
  st_t st;

  logic        bidx, need2, odd, pad_pend;
  logic [7:0]  whi, rlo, hold;
  logic [15:0] lcnt;

  wire req      = host_wr | host_rd;
  wire data_adr = (host_addr == 2'd0);
  wire wide     = bus16 & ~ctx_sel;
  wire bad      = (bus16 & host_addr[0])
                | (~bus16 & (host_addr == 2'd1))
                | (host_wr & host_addr[1])
                | (host_wr & ctx_sel & data_adr & (host_wdata[6:0] > SMAX));
  wire pad_now  = pad_pend & ~ctx_sel;
  wire rd_take  = (st == S_RD) & (pad_now | in_valid);
  wire [7:0] rd_byte = pad_now ? 8'h00 : in_data;

  assign in_ready = (st == S_RD) & ~pad_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      host_ack   <= 1'b0;
      host_err   <= 1'b0;
      host_rdata <= '0;
      out_valid  <= 1'b0;
      out_data   <= '0;
      whi        <= '0;
      rlo        <= '0;
      hold       <= '0;
      bidx       <= 1'b0;
      need2      <= 1'b0;
    end else begin
      host_ack <= 1'b0;
      host_err <= 1'b0;
      case (st)
        S_IDLE: if (req) begin
          bidx  <= 1'b0;
          need2 <= wide;
          if (bad) begin
            host_err <= 1'b1;
            host_ack <= 1'b1;
            st       <= S_ACK;
          end else if (host_wr) begin
            out_valid <= 1'b1;
            out_data  <= host_wdata[7:0];
            whi       <= host_wdata[15:8];
            st        <= S_WR;
          end else if (data_adr) begin
            st <= S_RD;
          end else begin
            if (host_addr == 2'd2) begin
              host_rdata <= bus16 ? lcnt : {8'h00, lcnt[7:0]};
              hold       <= lcnt[15:8];
            end else begin
              host_rdata <= {8'h00, hold};
            end
            host_ack <= 1'b1;
            st       <= S_ACK;
          end
        end
        S_WR: if (out_ready) begin
          if (need2 && !bidx) begin
            out_data <= whi;
            bidx     <= 1'b1;
          end else begin
            out_valid <= 1'b0;
            host_ack  <= 1'b1;
            st        <= S_ACK;
          end
        end
        S_RD: if (rd_take) begin
          if (need2 && !bidx) begin
            rlo  <= rd_byte;
            bidx <= 1'b1;
          end else begin
            host_rdata <= need2 ? {rd_byte, rlo} : {8'h00, rd_byte};
            host_ack   <= 1'b1;
            st         <= S_ACK;
          end
        end
        S_ACK: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      odd      <= 1'b0;
      pad_pend <= 1'b0;
    end else if (proc_start) begin
      odd      <= 1'b0;
      pad_pend <= 1'b0;
    end else if (rd_take && !ctx_sel) begin
      if (pad_now) begin
        pad_pend <= 1'b0;
      end else if (in_last) begin
        odd      <= 1'b0;
        pad_pend <= ~odd;
      end else begin
        odd <= ~odd;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcnt      <= '0;
      line_done <= 1'b0;
    end else if (proc_start) begin
      lcnt      <= '0;
      line_done <= 1'b0;
    end else if (line_tick && !line_done) begin
      lcnt <= lcnt + 16'd1;
      if ((lcnt + 16'd1) == line_target) line_done <= 1'b1;
    end
  end
endmodule

// File: rtl/hdp_width_adapter_chk.sv
module hdp_width_adapter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_ack,
  input logic       host_err,
  input logic       out_valid,
  input logic [7:0] out_data,
  input logic       out_ready,
  input logic       in_ready,
  input logic       proc_start,
  input logic       line_tick,
  input logic       line_done
);
  a_r11_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  a_r11_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |=> !host_ack);
  a_r11_dir_excl: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);
  a_r4_err_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    host_err |-> host_ack);
  a_r10_done_by_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_done) |-> $past(line_tick));
  a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    line_done && !proc_start |=> line_done);
  a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    proc_start |=> !line_done);
endmodule

bind hdp_width_adapter hdp_width_adapter_chk u_chk (.*);

// File: tb/sim_hdp_width_adapter.sv
`timescale 1ns/1ps
module sim_hdp_width_adapter;
  logic clk = 0, rst_n = 0;
  logic bus16 = 0, ctx_sel = 0, host_wr = 0, host_rd = 0;
  logic [1:0] host_addr = 0;
  logic [15:0] host_wdata = 0, host_rdata, line_target = 16'd600;
  logic host_ack, host_err, out_valid, out_ready, in_valid, in_last, in_ready;
  logic [7:0] out_data, in_data;
  logic proc_start = 0, line_tick = 0, line_done;

  int n_tests = 0, n_fail = 0;
  logic [7:0] sink_q[$], exp_q[$];
  logic [8:0] src_d[$];
  int src_idx = 0;
  bit src_fire = 0, snk_fire = 0;
  logic [7:0] snk_cap;

  always #2.5 clk = ~clk;

  hdp_width_adapter u0 (.*);

  initial begin in_valid = 0; in_data = 0; in_last = 0; out_ready = 0; end

  always @(negedge clk) if (rst_n) begin
    if (src_fire) src_idx++;
    in_valid = (src_idx < src_d.size()) && ($urandom % 4 != 0);
    if (src_idx < src_d.size()) {in_last, in_data} = src_d[src_idx];
    src_fire = in_valid && in_ready;
  end

  always @(negedge clk) if (rst_n) begin
    if (snk_fire) sink_q.push_back(snk_cap);
    out_ready = ($urandom % 3 != 0);
    snk_fire = out_valid && out_ready;
    snk_cap = out_data;
  end

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic acc(bit wr, logic [1:0] a, logic [15:0] d,
                     output logic [15:0] rv, output logic er);
    @(negedge clk);
    host_wr = wr; host_rd = !wr; host_addr = a; host_wdata = d;
    do @(negedge clk); while (!host_ack);
    rv = host_rdata; er = host_err;
    host_wr = 0; host_rd = 0;
  endtask

  task automatic wr_chk(string r, logic [1:0] a, logic [15:0] d, bit exp_err);
    logic [15:0] v; logic e;
    acc(1, a, d, v, e);
    chk(r, {31'b0, e}, {31'b0, exp_err});
  endtask

  task automatic rd_chk(string r, logic [1:0] a, logic [15:0] exp, bit exp_err);
    logic [15:0] v; logic e;
    acc(0, a, 16'h0, v, e);
    if (exp_err) chk(r, {31'b0, e}, 32'd1);
    else chk(r, {15'b0, e, v}, {16'b0, exp});
  endtask

  task automatic sink_cmp(string r);
    repeat (4) @(negedge clk);
    chk(r, sink_q.size(), exp_q.size());
    foreach (exp_q[i]) if (i < sink_q.size()) chk(r, sink_q[i], exp_q[i]);
    sink_q.delete(); exp_q.delete();
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); line_tick = 1;
      @(negedge clk); line_tick = 0;
    end
  endtask

  task automatic start_pulse();
    @(negedge clk); proc_start = 1;
    @(negedge clk); proc_start = 0;
  endtask

  task automatic coded_group(int len, bit w16);
    logic [7:0] e[$];
    for (int i = 0; i < len; i++) begin
      logic [7:0] b = 8'($urandom);
      src_d.push_back({i == len - 1, b});
      e.push_back(b);
    end
    if (len % 2) e.push_back(8'h00);
    bus16 = w16;
    if (w16) for (int i = 0; i < e.size(); i += 2) rd_chk("R3/R5 word", 0, {e[i+1], e[i]}, 0);
    else foreach (e[i]) rd_chk("R3/R5 byte", 0, {8'h00, e[i]}, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int s0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R11 reset out_valid", out_valid, 0);
    chk("R11 reset in_ready", in_ready, 0);
    chk("R11 reset host_ack", host_ack, 0);
    chk("R10 reset line_done", line_done, 0);
    rst_n = 1;
    start_pulse();

    bus16 = 0; ctx_sel = 0;
    for (int i = 0; i < 24; i++) begin
      d = 16'($urandom); exp_q.push_back(d[7:0]);
      wr_chk("R1 err", 0, d, 0);
    end
    sink_cmp("R1 bytes");

    bus16 = 1;
    for (int i = 0; i < 16; i++) begin
      d = 16'($urandom); exp_q.push_back(d[7:0]); exp_q.push_back(d[15:8]);
      wr_chk("R2 err", 0, d, 0);
    end
    sink_cmp("R2 bytes");

    s0 = src_d.size();
    coded_group(7, 0);
    coded_group(4, 0);
    coded_group(5, 1);
    coded_group(6, 1);
    repeat (3) @(negedge clk);
    chk("R5 pad consumes nothing", src_idx, src_d.size());
    for (int k = 0; k < 8; k++) coded_group(1 + $urandom % 9, k % 2);
    chk("R5 stream fully consumed", src_idx, src_d.size());

    s0 = src_idx;
    bus16 = 1;
    wr_chk("R4 odd addr 16", 1, 16'h1234, 1);
    rd_chk("R4 odd addr rd 16", 3, 0, 1);
    bus16 = 0;
    rd_chk("R4 addr1 in 8", 1, 0, 1);
    wr_chk("R4 wr line lo", 2, 16'h0055, 1);
    wr_chk("R4 wr line hi", 3, 16'h0055, 1);
    sink_cmp("R4 nothing sent");
    chk("R4 nothing consumed", src_idx, s0);

    ctx_sel = 1; bus16 = 1;
    wr_chk("R6 ctx 0x85", 0, 16'hFF85, 0); exp_q.push_back(8'h85);
    wr_chk("R6 ctx 112", 0, 16'h00F0, 0); exp_q.push_back(8'hF0);
    wr_chk("R6 ctx 113 rejected", 0, 16'h0071, 1);
    bus16 = 0;
    wr_chk("R6 ctx 8-bit", 0, 16'hAA42, 0); exp_q.push_back(8'h42);
    wr_chk("R6 ctx 127 rejected", 0, 16'h00FF, 1);
    sink_cmp("R6 ctx bytes");

    bus16 = 1;
    src_d.push_back({1'b1, 8'h9C});
    rd_chk("R7 ctx read 16", 0, 16'h009C, 0);
    bus16 = 0;
    src_d.push_back({1'b1, 8'hE1});
    rd_chk("R7 ctx read 8", 0, 16'h00E1, 0);
    ctx_sel = 0;
    src_d.push_back({1'b0, 8'h5A});
    src_d.push_back({1'b1, 8'h33});
    rd_chk("R7 no ctx parity", 0, 16'h005A, 0);
    rd_chk("R7 no ctx parity", 0, 16'h0033, 0);
    src_d.push_back({1'b0, 8'h77});
    rd_chk("R7 no pad after even end", 0, 16'h0077, 0);
    src_d.pop_back(); src_d.push_back({1'b0, 8'h77});

    start_pulse();
    bus16 = 0;
    rd_chk("R8 cleared", 2, 16'h0000, 0);
    tick(511);
    rd_chk("R9 low byte", 2, 16'h00FF, 0);
    tick(2);
    rd_chk("R9 captured high", 3, 16'h0001, 0);
    rd_chk("R9 new low", 2, 16'h0001, 0);
    rd_chk("R9 new high", 3, 16'h0002, 0);
    bus16 = 1;
    rd_chk("R8 word", 2, 16'h0201, 0);
    tick(86);
    chk("R10 not yet", line_done, 0);
    tick(1);
    chk("R10 done at target", line_done, 1);
    tick(5);
    rd_chk("R10 ticks ignored", 2, 16'd600, 0);
    start_pulse();
    chk("R10 start clears done", line_done, 0);
    rd_chk("R8 start clears count", 2, 16'h0000, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule